// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard and Branch Control

This block is the interlock and steering logic of an in-order five-stage integer pipeline (fetch, decode, execute, memory access, writeback). It receives, once per cycle, the register fields and control flags of the instruction sitting in decode. It keeps its own narrow copy of the control fields of the instructions that have moved on into execute, memory and writeback. From these it produces the program-counter write enable, the hold for the decode pipeline register, the bubble request for the execute stage, the operand-bypass selects for the execute stage and for the decode-stage comparator, and the next-PC source.

Branch and jump decisions are made in decode, and the slot after every branch or jump always runs. For that reason the unit has no flush output. Redirects take effect at the end of the decode cycle. The instruction already fetched behind the branch moves on normally. Only two situations stop fetch: an instruction that reads a register being loaded by the instruction directly ahead of it, and a branch or jump whose compare operand is not yet available for bypass into decode.

The surrounding datapath holds the decode register while `id_hold` is high. The same decode instruction is then presented again in the next cycle. The register file is assumed to write in the first half of a cycle and read in the second, so a writeback result never needs a bypass into decode.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: The execute-stage operand selects `ex_fwd_a`/`ex_fwd_b` encode 2'b00 = register file, 2'b01 = memory-stage result, 2'b10 = writeback result. When both the memory and the writeback instruction write the needed register, 2'b01 wins.
- R2: No bypass is ever selected for register 0, even when an older instruction claims to write it. A stage that does not write a register is never a bypass source.
- R3: When the instruction in execute is a load whose destination is a used source of the valid decode instruction, that cycle shows `pc_we`=0, `id_hold`=1 and `ex_bubble`=1. It lasts one cycle only, after which the held instruction proceeds.
- R4: A bubble enters execute with valid, register-write and load flags all cleared, so it is never a bypass source in later stages.
- R5: A branch or jump in decode stalls while the instruction in execute writes one of its used operands. It also stalls while the instruction in memory is a load that writes one. A load directly ahead therefore costs two stall cycles, and a load two ahead costs one.
- R6: `id_fwd_a`/`id_fwd_b` are 1 when a branch or jump in decode reads a register that the non-load instruction in the memory stage writes (register 0 excluded), and 0 otherwise.
- R7: `npc_sel` is 2'b00 for sequential, 2'b01 for a taken branch (`id_is_branch` with `id_cond_true`), and 2'b10 for a jump. While stalled it is 2'b00.
- R8: A redirect never squashes or stalls: in the redirect cycle `pc_we`=1 and `ex_bubble`=0, and the following delay-slot instruction proceeds without a stall of its own.
- R9: Reset clears every tracked stage. Right after reset, a decode instruction that reads a register that an instruction loaded before reset would have written causes no stall and no bypass.
- R10: `pc_we`, `id_hold` and `ex_bubble` always act together: the PC is frozen exactly when decode holds and a bubble enters execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | REG_AW | First source register of decode instruction |
| id_rt | input | REG_AW | Second source register of decode instruction |
| id_use_rs | input | 1 | First source is read |
| id_use_rt | input | 1 | Second source is read |
| id_rd | input | REG_AW | Destination register of decode instruction |
| id_reg_wr | input | 1 | Decode instruction writes a register |
| id_is_load | input | 1 | Decode instruction is a load |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_is_jump | input | 1 | Decode instruction is a jump |
| id_cond_true | input | 1 | Decode comparator says the branch is taken |
| pc_we | output | 1 | PC register write enable |
| id_hold | output | 1 | Hold the decode pipeline register |
| ex_bubble | output | 1 | Insert a bubble into execute |
| ex_fwd_a | output | 2 | Execute first-operand bypass select |
| ex_fwd_b | output | 2 | Execute second-operand bypass select |
| id_fwd_a | output | 1 | Bypass memory result into comparator operand A |
| id_fwd_b | output | 1 | Bypass memory result into comparator operand B |
| npc_sel | output | 2 | Next-PC source select |

## Verification
The cases of interest are those where two functions act in the same cycle. One is a stall caused by a branch that depends on an ALU result in execute, while that same cycle's execute instruction needs a memory-stage bypass and the comparator's other operand is bypassed from memory. The other is a taken redirect while both comparator operands come from the memory stage, with the delay-slot cycle that follows using writeback bypasses. Each is provoked by a hand-laid instruction sequence. The expected values of every output in that cycle are computed from the stage contents, so a fault in one function cannot be hidden by another.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_REGF = 2'b00,
    FWD_MEM  = 2'b01,
    FWD_WB   = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'b00,
    NPC_BRANCH = 2'b01,
    NPC_JUMP   = 2'b10
  } npc_sel_e;

  localparam int unsigned N_OPND = 2;
endpackage

// File: rtl/hzd_rst_sync.sv
`timescale 1ns/1ps
module hzd_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/hzd_stage_regs.sv
`timescale 1ns/1ps
module hzd_stage_regs #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_reg_wr,
  input  logic              id_is_load,
  input  logic              bubble,
  output logic              ex_valid,
  output logic [REG_AW-1:0] ex_rs,
  output logic [REG_AW-1:0] ex_rt,
  output logic              ex_use_rs,
  output logic              ex_use_rt,
  output logic [REG_AW-1:0] ex_rd,
  output logic              ex_wr,
  output logic              ex_ld,
  output logic [REG_AW-1:0] mem_rd,
  output logic              mem_wr,
  output logic              mem_ld,
  output logic [REG_AW-1:0] wb_rd,
  output logic              wb_wr
);
  logic              ex_valid_d, ex_use_rs_d, ex_use_rt_d, ex_wr_d, ex_ld_d;
  logic [REG_AW-1:0] ex_rs_d, ex_rt_d, ex_rd_d;
  logic              take;

  // Next-state: either the decode instruction or an empty slot.
  always_comb begin
    take        = id_valid && !bubble;
    ex_valid_d  = take;
    ex_rs_d     = take ? id_rs : '0;
    ex_rt_d     = take ? id_rt : '0;
    ex_use_rs_d = take && id_use_rs;
    ex_use_rt_d = take && id_use_rt;
    ex_rd_d     = take ? id_rd : '0;
    ex_wr_d     = take && id_reg_wr;
    ex_ld_d     = take && id_is_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_valid  <= 1'b0;
      ex_rs     <= '0;
      ex_rt     <= '0;
      ex_use_rs <= 1'b0;
      ex_use_rt <= 1'b0;
      ex_rd     <= '0;
      ex_wr     <= 1'b0;
      ex_ld     <= 1'b0;
      mem_rd    <= '0;
      mem_wr    <= 1'b0;
      mem_ld    <= 1'b0;
      wb_rd     <= '0;
      wb_wr     <= 1'b0;
    end else begin
      ex_valid  <= ex_valid_d;
      ex_rs     <= ex_rs_d;
      ex_rt     <= ex_rt_d;
      ex_use_rs <= ex_use_rs_d;
      ex_use_rt <= ex_use_rt_d;
      ex_rd     <= ex_rd_d;
      ex_wr     <= ex_wr_d;
      ex_ld     <= ex_ld_d;
      mem_rd    <= ex_rd;
      mem_wr    <= ex_wr;
      mem_ld    <= ex_ld;
      wb_rd     <= mem_rd;
      wb_wr     <= mem_wr;
    end
  end

  AST_BUBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (!ex_valid && !ex_wr && !ex_ld)); // R4
endmodule

// File: rtl/hzd_fwd_sel.sv
`timescale 1ns/1ps
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              need,
  input  logic [REG_AW-1:0] src,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              wb_wr,
  input  logic [REG_AW-1:0] wb_rd,
  output logic [1:0]        sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = need && mem_wr && (mem_rd != '0) && (mem_rd == src);
    wb_hit  = need && wb_wr  && (wb_rd  != '0) && (wb_rd  == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_REGF;
  end

  AST_FWD_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == FWD_REGF)); // R2
  AST_FWD_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> !(mem_wr && (mem_rd == src))); // R1
endmodule

// File: rtl/hzd_stall_ctl.sv
`timescale 1ns/1ps
module hzd_stall_ctl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic              id_is_branch,
  input  logic              id_is_jump,
  input  logic              id_cond_true,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic              ex_ld,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic              mem_ld,
  output logic              stall,
  output logic [N_OPND-1:0] id_fwd,
  output logic [1:0]        npc_sel
);
  logic [N_OPND-1:0][REG_AW-1:0] src;
  logic [N_OPND-1:0]             used;
  logic [N_OPND-1:0]             ex_hit, mem_ld_hit, mem_alu_hit;
  logic                          resolves, load_use, dec_dep;
  npc_sel_e                      npc;

  assign src  = {id_rt, id_rs};
  assign used = {id_use_rt, id_use_rs};
  assign resolves = id_valid && (id_is_branch || id_is_jump);

  generate
    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
      always_comb begin
        ex_hit[k]      = id_valid && used[k] && ex_wr && (ex_rd != '0)
                         && (ex_rd == src[k]);
        mem_ld_hit[k]  = id_valid && used[k] && mem_wr && mem_ld
                         && (mem_rd != '0) && (mem_rd == src[k]);
        mem_alu_hit[k] = id_valid && used[k] && mem_wr && !mem_ld
                         && (mem_rd != '0) && (mem_rd == src[k]);
      end
      assign id_fwd[k] = resolves && mem_alu_hit[k];

      AST_DEC_FWD_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        id_fwd[k] |-> !mem_ld); // R6
    end
  endgenerate

  always_comb begin
    load_use = ex_ld && (|ex_hit);
    dec_dep  = resolves && ((|ex_hit) || (|mem_ld_hit));
    stall    = load_use || dec_dep;
    if (stall)                              npc = NPC_SEQ;
    else if (id_valid && id_is_jump)        npc = NPC_JUMP;
    else if (id_valid && id_is_branch && id_cond_true) npc = NPC_BRANCH;
    else                                    npc = NPC_SEQ;
  end

  assign npc_sel = npc;
endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_use_rs,
  input  logic              id_use_rt,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_reg_wr,
  input  logic              id_is_load,
  input  logic              id_is_branch,
  input  logic              id_is_jump,
  input  logic              id_cond_true,
  output logic              pc_we,
  output logic              id_hold,
  output logic              ex_bubble,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b,
  output logic              id_fwd_a,
  output logic              id_fwd_b,
  output logic [1:0]        npc_sel
);
  logic              rst_sync_n;
  logic              stall;
  logic [N_OPND-1:0] id_fwd;
  logic              ex_valid, ex_use_rs, ex_use_rt, ex_wr, ex_ld;
  logic [REG_AW-1:0] ex_rs, ex_rt, ex_rd;
  logic [REG_AW-1:0] mem_rd, wb_rd;
  logic              mem_wr, mem_ld, wb_wr;
  logic [N_OPND-1:0][REG_AW-1:0] ex_src;
  logic [N_OPND-1:0]             ex_need;
  logic [N_OPND-1:0][1:0]        ex_sel;

  hzd_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  hzd_stage_regs #(.REG_AW(REG_AW)) i_stage_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_rd(id_rd),
    .id_reg_wr(id_reg_wr), .id_is_load(id_is_load), .bubble(stall),
    .ex_valid(ex_valid), .ex_rs(ex_rs), .ex_rt(ex_rt),
    .ex_use_rs(ex_use_rs), .ex_use_rt(ex_use_rt), .ex_rd(ex_rd),
    .ex_wr(ex_wr), .ex_ld(ex_ld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ld(mem_ld),
    .wb_rd(wb_rd), .wb_wr(wb_wr)
  );

  hzd_stall_ctl #(.REG_AW(REG_AW)) i_stall_ctl (
    .clk(clk), .rst_n(rst_sync_n),
    .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
    .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_is_branch(id_is_branch), .id_is_jump(id_is_jump),
    .id_cond_true(id_cond_true),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_ld(ex_ld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ld(mem_ld),
    .stall(stall), .id_fwd(id_fwd), .npc_sel(npc_sel)
  );

  assign ex_src  = {ex_rt, ex_rs};
  assign ex_need = {ex_valid && ex_use_rt, ex_valid && ex_use_rs};

  generate
    for (genvar k = 0; k < N_OPND; k++) begin : g_ex_fwd
      hzd_fwd_sel #(.REG_AW(REG_AW)) i_fwd_sel (
        .clk(clk), .rst_n(rst_sync_n),
        .need(ex_need[k]), .src(ex_src[k]),
        .mem_wr(mem_wr), .mem_rd(mem_rd),
        .wb_wr(wb_wr), .wb_rd(wb_rd),
        .sel(ex_sel[k])
      );
    end
  endgenerate

  assign pc_we     = !stall;
  assign id_hold   = stall;
  assign ex_bubble = stall;
  assign ex_fwd_a  = ex_sel[0];
  assign ex_fwd_b  = ex_sel[1];
  assign id_fwd_a  = id_fwd[0];
  assign id_fwd_b  = id_fwd[1];

  AST_STALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pc_we) |-> (id_hold && ex_bubble)); // R10
  AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_valid && ex_valid && ex_ld && (ex_rd != '0) &&
     ((id_use_rs && (ex_rd == id_rs)) || (id_use_rt && (ex_rd == id_rt))))
    |-> (!pc_we && ex_bubble)); // R3
  AST_BRANCH_EX_DEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (id_valid && (id_is_branch || id_is_jump) && ex_wr && (ex_rd != '0) &&
     ((id_use_rs && (ex_rd == id_rs)) || (id_use_rt && (ex_rd == id_rt))))
    |-> !pc_we); // R5
  AST_REDIRECT_GOES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (npc_sel != NPC_SEQ) |-> (pc_we && !ex_bubble)); // R7
  AST_DELAY_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (npc_sel != NPC_SEQ) |=> (ex_valid == $past(id_valid))); // R8
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module test_pipe_hazard_ctrl;
  localparam int AW = 5;

  typedef struct packed {
    logic v; logic [AW-1:0] rs; logic [AW-1:0] rt; logic urs; logic urt;
    logic [AW-1:0] rd; logic wr; logic ld; logic br; logic jp; logic cond;
  } dec_t;

  typedef struct packed {
    logic pcwe; logic hold; logic bub; logic [1:0] fa; logic [1:0] fb;
    logic dfa; logic dfb; logic [1:0] npc;
  } exp_t;

  typedef struct { exp_t e; string tag; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  dec_t d = '0;
  logic pc_we, id_hold, ex_bubble, id_fwd_a, id_fwd_b;
  logic [1:0] ex_fwd_a, ex_fwd_b, npc_sel;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  item_t q[$];

  always #2.5 clk = ~clk;

  pipe_hazard_ctrl #(.REG_AW(AW)) i_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n),
    .id_valid(d.v), .id_rs(d.rs), .id_rt(d.rt),
    .id_use_rs(d.urs), .id_use_rt(d.urt), .id_rd(d.rd),
    .id_reg_wr(d.wr), .id_is_load(d.ld), .id_is_branch(d.br),
    .id_is_jump(d.jp), .id_cond_true(d.cond),
    .pc_we(pc_we), .id_hold(id_hold), .ex_bubble(ex_bubble),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
    .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b), .npc_sel(npc_sel)
  );

  function automatic dec_t alu(int rd, int rs, int rt);
    dec_t x = '0;
    x.v = 1; x.rd = AW'(rd); x.rs = AW'(rs); x.rt = AW'(rt);
    x.urs = 1; x.urt = 1; x.wr = 1;
    return x;
  endfunction
  function automatic dec_t ldw(int rd, int rs);
    dec_t x = '0;
    x.v = 1; x.rd = AW'(rd); x.rs = AW'(rs); x.urs = 1; x.wr = 1; x.ld = 1;
    return x;
  endfunction
  function automatic dec_t brc(int rs, int rt, bit taken);
    dec_t x = '0;
    x.v = 1; x.rs = AW'(rs); x.rt = AW'(rt); x.urs = 1; x.urt = 1;
    x.br = 1; x.cond = taken;
    return x;
  endfunction
  function automatic dec_t jmp();
    dec_t x = '0;
    x.v = 1; x.jp = 1;
    return x;
  endfunction
  function automatic dec_t nop();
    dec_t x = '0;
    x.v = 1;
    return x;
  endfunction
  // st=1: frozen PC, held decode, bubble.
  function automatic exp_t ex(bit st, logic [1:0] fa, logic [1:0] fb,
                              bit dfa, bit dfb, logic [1:0] npc);
    exp_t e;
    e.pcwe = !st; e.hold = st; e.bub = st;
    e.fa = fa; e.fb = fb; e.dfa = dfa; e.dfb = dfb; e.npc = npc;
    return e;
  endfunction

  // Driver: present decode instruction, queue expected result, clock it.
  task automatic step(input dec_t di, input exp_t e, input string tag);
    item_t it;
    @(negedge clk);
    d = di;
    it.e = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: compare outputs 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      exp_t act;
      it = q.pop_front();
      act = {pc_we, id_hold, ex_bubble, ex_fwd_a, ex_fwd_b,
             id_fwd_a, id_fwd_b, npc_sel};
      checks++;
      if (act !== it.e) begin
        errors++;
        $display("FAIL %s act=%b exp=%b (pcwe,hold,bub,fa,fb,dfa,dfb,npc)",
                 it.tag, act, it.e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    d = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9: empty pipeline after reset, R7 taken branch redirect
    step(brc(5, 6, 1), ex(0, 2'b00, 2'b00, 0, 0, 2'b01), "R9/R7 reset state, taken branch");
    step(alu(1, 2, 3), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R8 delay slot after reset branch");
    step(alu(4, 1, 1), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R1 no producer yet");
    step(alu(5, 1, 4), ex(0, 2'b01, 2'b01, 0, 0, 2'b00), "R1 both from memory");
    step(nop(),        ex(0, 2'b10, 2'b01, 0, 0, 2'b00), "R1 mixed wb and memory");
    step(alu(1, 7, 7), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R1 nop in execute");
    step(alu(1, 8, 8), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R1 unrelated");
    step(alu(9, 1, 0), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R1 unrelated 2");
    step(alu(0, 1, 1), ex(0, 2'b01, 2'b00, 0, 0, 2'b00), "R1 memory beats wb; R2 r0 source");
    step(alu(2, 0, 3), ex(0, 2'b10, 2'b10, 0, 0, 2'b00), "R1 both from wb");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R2 r0 write not bypassed");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R2 drain");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R2 drain 2");
    // R3 load-use
    step(ldw(3, 2),    ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R3 load enters");
    step(alu(4, 3, 5), ex(1, 2'b00, 2'b00, 0, 0, 2'b00), "R3 load-use stall");
    step(alu(4, 3, 5), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R3 single stall cycle");
    step(nop(),        ex(0, 2'b10, 2'b00, 0, 0, 2'b00), "R4 bubble skipped, wb bypass");
    // R5 load two ahead of branch
    step(ldw(6, 2),    ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R5 load");
    step(alu(7, 8, 9), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R3 independent after load");
    step(brc(6, 0, 1), ex(1, 2'b00, 2'b00, 0, 0, 2'b00), "R5 load two ahead stall, R7 no redirect");
    step(brc(6, 0, 1), ex(0, 2'b00, 2'b00, 0, 0, 2'b01), "R5 one cycle then R7 redirect");
    step(alu(10, 7, 7), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R8 delay slot proceeds");
    step(alu(11, 10, 1), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R8 target instruction");
    // same-cycle: stall with execute bypass and decode bypass
    step(brc(11, 10, 0), ex(1, 2'b01, 2'b00, 0, 1, 2'b00), "R5/R1/R6 stall with bypasses");
    step(brc(11, 10, 0), ex(0, 2'b00, 2'b00, 1, 0, 2'b00), "R6 decode bypass, R7 not taken");
    step(jmp(),        ex(0, 2'b10, 2'b00, 0, 0, 2'b10), "R7 jump, R1 wb");
    step(ldw(12, 1),   ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R8 jump delay slot");
    // R5 load directly ahead of branch: two stalls
    step(brc(12, 1, 1), ex(1, 2'b00, 2'b00, 0, 0, 2'b00), "R5 load adjacent stall 1");
    step(brc(12, 1, 1), ex(1, 2'b00, 2'b00, 0, 0, 2'b00), "R5 load adjacent stall 2");
    step(brc(12, 1, 1), ex(0, 2'b00, 2'b00, 0, 0, 2'b01), "R5 released, R7 taken");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R8 slot after stalled branch");
    // same-cycle: redirect with decode bypass on both operands
    step(alu(13, 2, 2), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R6 producer");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R6 spacer");
    step(brc(13, 13, 1), ex(0, 2'b00, 2'b00, 1, 1, 2'b01), "R6/R7 redirect with bypass");
    step(nop(),        ex(0, 2'b10, 2'b10, 0, 0, 2'b00), "R8/R1 slot with wb bypass");
    step(ldw(14, 1),   ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R9 load before reset");
    do_reset();
    step(alu(15, 14, 14), ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R9 no stall after reset");
    step(nop(),        ex(0, 2'b00, 2'b00, 0, 0, 2'b00), "R10 quiet");

    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule